// File: doc/BRIEF.md
# Pipelined 32x32 Split Multiplier

This block multiplies two 32-bit operands and returns one 32-bit word of the 64-bit product. It is intended for a processor execute path, or for any datapath that needs a full-rate multiply. Each operand carries its own signedness flag. A word-select input picks either the low word or the high word of the product. With those three controls the block covers the four usual integer multiply forms: low word, high signed×signed, high signed×unsigned and high unsigned×unsigned.

The product is never formed by one wide multiplier. Each operand is extended to 33 bits according to its flag, then split into a 16-bit unsigned low half and a 17-bit signed high half. Four 17x17 signed sub-products are each small enough for an 18x18 hardware multiply primitive. They are captured in the first register stage. The second stage adds the two cross products. The third stage joins all the terms into the 64-bit product, selects the requested word and registers it. A control word and a valid bit travel with the data through every stage.

Both edges are valid/ready streams. The whole pipeline advances as one unit whenever the output register is empty or is being taken. `in_ready` reflects that condition, and an operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, the pipeline freezes: the result is held, nothing is lost and nothing is duplicated. Bubbles inside the pipeline are not squeezed out during a stall.

Top module: `smul32_pipe`

## Requirements
- R1: An operation is accepted on a rising edge exactly when `in_valid` and `in_ready` are both high, and `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R2: With `out_ready` held high, the result of an accepted operation is on `out_result` with `out_valid` high right after the third rising edge, counting the accepting edge as the first.
- R3: With `out_ready` held high, a new operation is accepted on every clock, and results leave in acceptance order, one per clock.
- R4: With `in_sel_high`=1 and both signedness flags 0, `out_result` is bits 63:32 of the unsigned 64-bit product.
- R5: With `in_sel_high`=1 and both flags 1, `out_result` is bits 63:32 of the two's-complement product, including for operands 0x80000000 and 0xFFFFFFFF.
- R6: With `in_sel_high`=1 and exactly one flag set, the flagged operand is taken as signed and the other as unsigned, and `out_result` is bits 63:32 of that product.
- R7: With `in_sel_high`=0, `out_result` is bits 31:0 of the product, which are the same for every combination of the flags.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` does not change on the next edge, and no accepted operation is dropped or repeated.
- R9: A synchronous active-high `rst` clears every stage's valid bit. After reset `out_valid` is 0 and `in_ready` is 1, and operations in flight at reset produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Pipeline can take an operation this cycle |
| in_a | input | 32 | Multiplicand |
| in_b | input | 32 | Multiplier |
| in_a_signed | input | 1 | 1: `in_a` is two's complement |
| in_b_signed | input | 1 | 1: `in_b` is two's complement |
| in_sel_high | input | 1 | 1: return product bits 63:32, 0: bits 31:0 |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Selected product word |

## Verification
Accepting a new operation and holding a stalled result are the two functions that meet in the same cycle. When `out_ready` drops while `in_valid` stays high, `in_ready` must fall in that same cycle, and the offered operation must wait without entering the pipeline. The bench provokes this by toggling `out_ready` at random under a long stream of back-to-back operations with random signedness and word select. It judges the result through a scoreboard: every accepted operation has to come out exactly once, in order, with the right value, and a stalled result must still be there, unchanged, one edge later.

// File: rtl/smul_pkg.sv
`timescale 1ns/1ps
package smul_pkg;
  typedef enum logic {
    WORD_LO = 1'b0,
    WORD_HI = 1'b1
  } word_sel_e;

  typedef struct packed {
    logic      a_sgn;
    logic      b_sgn;
    word_sel_e sel;
  } op_ctrl_t;
endpackage

// File: rtl/smul_split.sv
`timescale 1ns/1ps
// Extends an operand by one bit according to its signedness, then cuts it
// into an unsigned low half (zero padded) and a signed high half.
module smul_split #(
  parameter int DW   = 32,
  parameter int LO_W = 16,
  localparam int HI_W = DW + 1 - LO_W
) (
  input  logic [DW-1:0]   op,
  input  logic            sgn,
  output logic [HI_W-1:0] lo_half,
  output logic [HI_W-1:0] hi_half
);
  logic [DW:0] ext;

  always_comb begin
    ext     = {sgn & op[DW-1], op};
    lo_half = {{(HI_W-LO_W){1'b0}}, ext[LO_W-1:0]};
    hi_half = ext[DW:LO_W];
  end
endmodule

// File: rtl/smul_stage1.sv
`timescale 1ns/1ps
// Stage 1: four narrow signed sub-products, registered.
// Index k: bit0 picks the half of A, bit1 the half of B (0 = low, 1 = high).
module smul_stage1
  import smul_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LO_W = 16,
  localparam int HI_W = DW + 1 - LO_W,
  localparam int PW   = 2 * HI_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                v_in,
  input  logic [DW-1:0]       a,
  input  logic [DW-1:0]       b,
  input  op_ctrl_t            ctrl_in,
  output logic                v_out,
  output op_ctrl_t            ctrl_out,
  output logic [3:0][PW-1:0]  pp
);
  logic [1:0][HI_W-1:0] a_h;
  logic [1:0][HI_W-1:0] b_h;
  logic [3:0][PW-1:0]   prod;

  smul_split #(.DW(DW), .LO_W(LO_W)) u_split_a (
    .op(a), .sgn(ctrl_in.a_sgn), .lo_half(a_h[0]), .hi_half(a_h[1])
  );
  smul_split #(.DW(DW), .LO_W(LO_W)) u_split_b (
    .op(b), .sgn(ctrl_in.b_sgn), .lo_half(b_h[0]), .hi_half(b_h[1])
  );

  for (genvar k = 0; k < 4; k++) begin : g_sub
    logic signed [PW-1:0] p_k;
    assign p_k     = $signed(a_h[k % 2]) * $signed(b_h[k / 2]);
    assign prod[k] = p_k;
  end

  always_ff @(posedge clk) begin
    if (rst)      v_out <= 1'b0;
    else if (en)  v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      pp       <= prod;
      ctrl_out <= ctrl_in;
    end
  end

  // R7: low*low is a product of two zero-padded halves, never negative
  p_ll_nonneg_r7: assert property (@(posedge clk) disable iff (rst)
    v_out |-> !pp[0][PW-1]);
  // R4: with both operands unsigned the high halves are non-negative
  p_hh_unsigned_r4: assert property (@(posedge clk) disable iff (rst)
    (v_out && !ctrl_out.a_sgn && !ctrl_out.b_sgn) |-> !pp[3][PW-1]);
endmodule

// File: rtl/smul_stage2.sv
`timescale 1ns/1ps
// Stage 2: sum the two cross products, carry the outer terms along.
module smul_stage2
  import smul_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LO_W = 16,
  localparam int HI_W = DW + 1 - LO_W,
  localparam int PW   = 2 * HI_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               v_in,
  input  op_ctrl_t           ctrl_in,
  input  logic [3:0][PW-1:0] pp,
  output logic               v_out,
  output op_ctrl_t           ctrl_out,
  output logic [PW-1:0]      ll,
  output logic [PW:0]        mid,
  output logic [PW-1:0]      hh
);
  logic [PW:0] cross_sum;

  always_comb begin
    cross_sum = {pp[1][PW-1], pp[1]} + {pp[2][PW-1], pp[2]};
  end

  always_ff @(posedge clk) begin
    if (rst)      v_out <= 1'b0;
    else if (en)  v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      ll       <= pp[0];
      hh       <= pp[3];
      mid      <= cross_sum;
      ctrl_out <= ctrl_in;
    end
  end
endmodule

// File: rtl/smul_stage3.sv
`timescale 1ns/1ps
// Stage 3: align and add the terms, pick the requested word, register it.
module smul_stage3
  import smul_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LO_W = 16,
  localparam int HI_W = DW + 1 - LO_W,
  localparam int PW   = 2 * HI_W,
  localparam int FW   = PW + 2 * LO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          v_in,
  input  op_ctrl_t      ctrl_in,
  input  logic [PW-1:0] ll,
  input  logic [PW:0]   mid,
  input  logic [PW-1:0] hh,
  output logic          v_out,
  output logic [DW-1:0] word
);
  logic [FW-1:0] t_hh, t_mid, t_ll, full;
  logic [DW-1:0] picked;

  always_comb begin
    t_hh   = {hh, {(2*LO_W){1'b0}}};
    t_mid  = {{(FW-PW-1-LO_W){mid[PW]}}, mid, {LO_W{1'b0}}};
    t_ll   = {{(FW-PW){ll[PW-1]}}, ll};
    full   = t_hh + t_mid + t_ll;
    picked = (ctrl_in.sel == WORD_HI) ? full[2*DW-1:DW] : full[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      v_out <= 1'b0;
    else if (en)  v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) word <= picked;
  end
endmodule

// File: rtl/smul32_pipe.sv
`timescale 1ns/1ps
module smul32_pipe
  import smul_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LO_W = 16,
  localparam int HI_W = DW + 1 - LO_W,
  localparam int PW   = 2 * HI_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic          in_a_signed,
  input  logic          in_b_signed,
  input  logic          in_sel_high,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result
);
  logic               adv;
  op_ctrl_t           ctrl_0, ctrl_1, ctrl_2;
  logic               v1, v2;
  logic [3:0][PW-1:0] pp1;
  logic [PW-1:0]      ll2, hh2;
  logic [PW:0]        mid2;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_comb begin
    ctrl_0.a_sgn = in_a_signed;
    ctrl_0.b_sgn = in_b_signed;
    ctrl_0.sel   = in_sel_high ? WORD_HI : WORD_LO;
  end

  smul_stage1 #(.DW(DW), .LO_W(LO_W)) u_s1 (
    .clk(clk), .rst(rst), .en(adv), .v_in(in_valid),
    .a(in_a), .b(in_b), .ctrl_in(ctrl_0),
    .v_out(v1), .ctrl_out(ctrl_1), .pp(pp1)
  );

  smul_stage2 #(.DW(DW), .LO_W(LO_W)) u_s2 (
    .clk(clk), .rst(rst), .en(adv), .v_in(v1), .ctrl_in(ctrl_1), .pp(pp1),
    .v_out(v2), .ctrl_out(ctrl_2), .ll(ll2), .mid(mid2), .hh(hh2)
  );

  smul_stage3 #(.DW(DW), .LO_W(LO_W)) u_s3 (
    .clk(clk), .rst(rst), .en(adv), .v_in(v2), .ctrl_in(ctrl_2),
    .ll(ll2), .mid(mid2), .hh(hh2),
    .v_out(out_valid), .word(out_result)
  );

  // R1: a handshake at the input loads stage one
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> v1);
  // R2: an operation in stage two reaches the output on an advancing edge
  p_flow_r2: assert property (@(posedge clk) disable iff (rst)
    (v2 && in_ready) |=> out_valid);
  // R8: a refused result is held unchanged
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));
endmodule

// File: tb/test_smul32_pipe.sv
`timescale 1ns/1ps
module test_smul32_pipe;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [31:0] in_a, in_b;
  logic        in_a_signed, in_b_signed, in_sel_high;
  logic        out_valid, out_ready;
  logic [31:0] out_result;

  always #4 clk = ~clk;

  smul32_pipe i_smul32_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_a_signed(in_a_signed),
    .in_b_signed(in_b_signed), .in_sel_high(in_sel_high),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  typedef struct {
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  int   stalls = 0;
  int   ready_mode = 0;
  bit   prev_stall = 0;
  logic [31:0] prev_res;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                        bit sa, bit sb, bit hi);
    logic signed [32:0] ea, eb;
    logic signed [65:0] p;
    ea = {sa & a[31], a};
    eb = {sb & b[31], b};
    p  = ea * eb;
    return hi ? p[63:32] : p[31:0];
  endfunction

  function automatic string tag(bit sa, bit sb, bit hi);
    if (!hi) return "R7";
    if (sa && sb) return "R5";
    if (sa || sb) return "R6";
    return "R4";
  endfunction

  // driver: offer at negedge+1, handshake judged at negedge+2
  task automatic drive_op(logic [31:0] a, logic [31:0] b, bit sa, bit sb, bit hi);
    exp_t e;
    @(negedge clk); #1;
    in_valid = 1; in_a = a; in_b = b;
    in_a_signed = sa; in_b_signed = sb; in_sel_high = hi;
    #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk); #2;
    end
    e.val = model(a, b, sa, sb, hi);
    e.req = tag(sa, sb, hi);
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk); #1;
    in_valid = 0;
  endtask

  // ready generator
  always begin
    @(negedge clk); #1;
    out_ready = (ready_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
  end

  // monitor / scoreboard
  always begin
    @(negedge clk); #2;
    if (rst) begin
      prev_stall = 0;
    end else begin
      if (prev_stall)
        check(out_valid && out_result == prev_res, "R8", out_result, prev_res);
      prev_stall = out_valid && !out_ready;
      prev_res   = out_result;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 spurious", out_result, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_result == e.val, e.req, out_result, e.val);
        end
      end
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst = 1; in_valid = 0; in_a = 0; in_b = 0;
    in_a_signed = 0; in_b_signed = 0; in_sel_high = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    #1 rst = 0;
    #1;
    // R9: reset state
    check(out_valid == 0, "R9", {31'b0, out_valid}, 32'h0);
    check(in_ready == 1, "R9", {31'b0, in_ready}, 32'h1);

    // R2: latency
    begin
      int n = 0;
      drive_op(32'd7, 32'd9, 0, 0, 0);
      idle();
      #2;
      n = 1;
      while (!out_valid && n < 10) begin
        @(negedge clk); #3;
        n++;
      end
      check(n == 3, "R2", n, 3);
    end
    repeat (3) idle();

    // directed corners under free output
    drive_op(32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 1); // R4 -> fffffffe
    drive_op(32'h80000000, 32'h80000000, 1, 1, 1); // R5 -> 40000000
    drive_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1, 1, 1); // R5 -> 0
    drive_op(32'h80000000, 32'h7FFFFFFF, 1, 1, 1); // R5
    drive_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1, 0, 1); // R6 -> ffffffff
    drive_op(32'h00000003, 32'hFFFFFFFE, 0, 1, 1); // R6
    drive_op(32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0); // R7 -> 1
    drive_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1, 1, 0); // R7 -> 1
    drive_op(32'h12345678, 32'h9ABCDEF0, 1, 0, 0); // R7
    drive_op(32'h0001FFFF, 32'h0001FFFF, 0, 0, 1); // R4 carry across halves
    repeat (4) idle();

    // R3: back-to-back with no stall
    stalls = 0;
    for (int i = 0; i < 16; i++)
      drive_op($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
    check(stalls == 0, "R3", stalls, 0);
    repeat (4) idle();

    // R1/R8: random back-pressure with a long stream
    ready_mode = 1;
    for (int i = 0; i < 300; i++)
      drive_op($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
    check(stalls > 0, "R1", stalls, 1);
    idle();
    ready_mode = 0;
    repeat (6) idle();
    check(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);

    // R9: reset with operations in flight
    drive_op(32'd5, 32'd6, 0, 0, 0);
    drive_op(32'd8, 32'd3, 0, 0, 0);
    @(negedge clk); #1;
    in_valid = 0; rst = 1;
    exp_q.delete();
    @(negedge clk); #1;
    rst = 0;
    #1;
    check(out_valid == 0, "R9", {31'b0, out_valid}, 32'h0);
    check(in_ready == 1, "R9", {31'b0, in_ready}, 32'h1);
    repeat (5) idle();
    report();
  end
endmodule